// File: doc/BRIEF.md
# Glitch-Free Pin-Steered Dual-Rate Clock Selector

This block gives each of several output clock channels a choice of two incoming clocks. The two clocks stand for two preset rates, called the primary (A) and the alternate (B) rate. Two asynchronous external select pins make the choice. A static map, captured while reset is held, binds every selectable channel to one of those pins. Any set of channels can follow either pin, and both pins can be in use at once.

When a channel's selected level changes, the channel changes clocks without glitches. The running clock first completes the period in progress. The output then stays low until the incoming clock produces its own rising edge. Each channel has a two-flop synchroniser in each of its two clock domains. A cross-coupled pair of enables ensures that at most one source drives the output. Channels with an index at or above the selectable count have no select function and always pass their primary clock. The block contains only clock steering: it does not generate rates, divide or lock anything.

Top module: `clk_freq_select`

## Requirements
- R1: While `rst_n` is low, every selectable channel outputs its A clock whatever the pin levels. After reset is released it keeps doing so for at least the next two rising edges of its A clock.
- R2: Once the select level seen by a channel has been steady for the handover time, the channel outputs its A clock when that level is 0 and its B clock when that level is 1.
- R3: Channel c is steered by pin `fs_pin[m]`, where m is map field c (`map_sel[c*MAPW +: MAPW]`; with the defaults, bit c). Field value 0 selects pin 0 and field value 1 selects pin 1, and any mix of channels per pin is allowed.
- R4: The map is taken in only while `rst_n` is low. Changes to `map_sel` after reset is released do not alter which pin steers any channel.
- R5: Channels with an index of NSEL or higher always output their A clock. The pins and the map have no effect on them.
- R6: Every high pulse on a channel output is a complete high phase of one of its source clocks. No period in progress is cut short by a change of selection.
- R7: After a handover, the new clock first appears at one of its own rising edges. Every low interval on the output lasts at least a full low phase of a source clock, and the two source enables of a channel are never on at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset; the map is captured while it is low |
| fs_pin | input | NPIN | Asynchronous select pins; level 0 picks A, level 1 picks B |
| map_sel | input | NSEL*MAPW | Per-channel pin index fields, channel c at bits c*MAPW upward |
| clk_a | input | NCH | Primary-rate source clock per channel |
| clk_b | input | NSEL | Alternate-rate source clock per selectable channel |
| clk_out | output | NCH | Selected clock per channel |

## Verification
The bench builds the block with its defaults: eight channels, six of them selectable, and two select pins, so each map field is one bit wide. This covers both map values on every selectable channel, mixed maps in which both pins steer channels at the same time, and two fixed channels that must ignore all pin activity. The source clocks run at 20 ns and 14 ns periods with unrelated phases. Handovers therefore land at many different phase offsets, and a pulse-width monitor can tell a full high phase of either source apart from a truncated one.

// File: rtl/fsel_pkg.sv
`timescale 1ns/1ps
package fsel_pkg;
  // Default number of external select pins.
  localparam int unsigned FSEL_NPIN = 2;

  // Width of an index able to address n items (at least one bit).
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fsel_sync2.sv
`timescale 1ns/1ps
// Two-stage synchroniser with a selectable reset level.
module fsel_sync2 #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/fsel_gate_mux.sv
`timescale 1ns/1ps
// One selectable channel: map capture, pin pick, cross-coupled
// enable handover and the final clock gate.
module fsel_gate_mux #(
  parameter int unsigned NPIN = 2,
  parameter int unsigned MAPW = 1
) (
  input  logic            clk_a,
  input  logic            clk_b,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins,
  input  logic [MAPW-1:0] map_in,
  output logic            clk_o,
  output logic            en_a_o,
  output logic            en_b_o
);
  logic [MAPW-1:0] map_q;
  logic            sel_raw;
  logic            req_a, req_b;
  logic            req_a_s, req_b_s;
  logic            en_a, en_b;

  // Static configuration: loaded only while reset is held.
  always_ff @(posedge clk_a) begin
    if (!rst_n) map_q <= map_in;
  end

  always_comb begin
    sel_raw = 1'b0;
    for (int p = 0; p < NPIN; p++) begin
      if (map_q == MAPW'(p)) sel_raw = pins[p];
    end
  end

  // Each side asks for the output only while the other side is off.
  assign req_a = ~sel_raw & ~en_b;
  assign req_b =  sel_raw & ~en_a;

  fsel_sync2 #(.RST_VAL(1'b1)) u_sync_a (
    .clk(clk_a), .rst_n(rst_n), .d(req_a), .q(req_a_s)
  );

  fsel_sync2 #(.RST_VAL(1'b0)) u_sync_b (
    .clk(clk_b), .rst_n(rst_n), .d(req_b), .q(req_b_s)
  );

  // Enables move on falling edges, while their own clock is low.
  always_ff @(negedge clk_a or negedge rst_n) begin
    if (!rst_n) en_a <= 1'b1;
    else        en_a <= req_a_s;
  end

  always_ff @(negedge clk_b or negedge rst_n) begin
    if (!rst_n) en_b <= 1'b0;
    else        en_b <= req_b_s;
  end

  assign clk_o  = (clk_a & en_a) | (clk_b & en_b);
  assign en_a_o = en_a;
  assign en_b_o = en_b;
endmodule

// File: rtl/clk_freq_select.sv
`timescale 1ns/1ps
// Top: NSEL pin-steered glitch-free channels plus fixed pass-through channels.
module clk_freq_select #(
  parameter int unsigned NCH  = 8,
  parameter int unsigned NSEL = 6,
  parameter int unsigned NPIN = fsel_pkg::FSEL_NPIN,
  localparam int unsigned MAPW = fsel_pkg::idx_w(NPIN)
) (
  input  logic                 rst_n,
  input  logic [NPIN-1:0]      fs_pin,
  input  logic [NSEL*MAPW-1:0] map_sel,
  input  logic [NCH-1:0]       clk_a,
  input  logic [NSEL-1:0]      clk_b,
  output logic [NCH-1:0]       clk_out
);
  logic [NSEL-1:0] en_a;
  logic [NSEL-1:0] en_b;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (c < NSEL) begin : g_sel
      fsel_gate_mux #(.NPIN(NPIN), .MAPW(MAPW)) u_mux (
        .clk_a  (clk_a[c]),
        .clk_b  (clk_b[c]),
        .rst_n  (rst_n),
        .pins   (fs_pin),
        .map_in (map_sel[c*MAPW +: MAPW]),
        .clk_o  (clk_out[c]),
        .en_a_o (en_a[c]),
        .en_b_o (en_b[c])
      );
    end else begin : g_fix
      assign clk_out[c] = clk_a[c];
    end
  end
endmodule

// File: rtl/fsel_checker.sv
`timescale 1ns/1ps
module fsel_checker #(
  parameter int unsigned NCH  = 8,
  parameter int unsigned NSEL = 6
) (
  input logic            rst_n,
  input logic [NCH-1:0]  clk_a,
  input logic [NSEL-1:0] clk_b,
  input logic [NCH-1:0]  clk_out,
  input logic [NSEL-1:0] en_a,
  input logic [NSEL-1:0] en_b
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    if (i < NSEL) begin : g_sel
      // R6: a gate only opens or closes while its own clock is low.
      always @(en_a[i]) begin
        if (rst_n) a_r6_gate_a_low: assert (!clk_a[i]);
      end
      always @(en_b[i]) begin
        if (rst_n) a_r6_gate_b_low: assert (!clk_b[i]);
      end
      // R7: never both sources enabled.
      a_r7_excl: assert property (@(posedge clk_a[i]) disable iff (!rst_n)
        $onehot0({en_a[i], en_b[i]}));
      // R7: a new enable rises only once the other one is off.
      a_r7_handover_b: assert property (@(posedge clk_b[i]) disable iff (!rst_n)
        $rose(en_b[i]) |-> !en_a[i]);
      a_r7_handover_a: assert property (@(posedge clk_a[i]) disable iff (!rst_n)
        $rose(en_a[i]) |-> !en_b[i]);
    end else begin : g_fix
      // R5: fixed channels track the A clock.
      a_r5_fixed_high: assert property (@(negedge clk_a[i]) disable iff (!rst_n)
        clk_out[i]);
      a_r5_fixed_low: assert property (@(posedge clk_a[i]) disable iff (!rst_n)
        !clk_out[i]);
    end
  end
endmodule

bind clk_freq_select fsel_checker #(.NCH(NCH), .NSEL(NSEL)) u_chk (
  .rst_n   (rst_n),
  .clk_a   (clk_a),
  .clk_b   (clk_b),
  .clk_out (clk_out),
  .en_a    (en_a),
  .en_b    (en_b)
);

// File: tb/clk_freq_select_test.sv
`timescale 1ns/1ps
module clk_freq_select_test;
  localparam int NCH  = 8;
  localparam int NSEL = 6;
  localparam int NPIN = 2;
  localparam int SETTLE = 24;

  typedef struct packed {
    logic [NSEL-1:0] map;
    logic [1:0]      fs;
    logic [NSEL-1:0] want_b;
  } row_t;

  // fs bit 0 is pin 0; map bit c = 1 ties channel c to pin 1.
  localparam row_t ROWS [9] = '{
    '{6'b000000, 2'b00, 6'b000000},
    '{6'b000000, 2'b01, 6'b111111},
    '{6'b000000, 2'b10, 6'b000000},
    '{6'b111111, 2'b10, 6'b111111},
    '{6'b111111, 2'b01, 6'b000000},
    '{6'b101001, 2'b01, 6'b010110},
    '{6'b101001, 2'b10, 6'b101001},
    '{6'b010110, 2'b11, 6'b111111},
    '{6'b010110, 2'b01, 6'b101001}
  };

  logic            bclk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NPIN-1:0] fs_pin = '0;
  logic [NSEL-1:0] map_sel = '0;
  logic [NCH-1:0]  clk_a = '0;
  logic [NSEL-1:0] clk_b = '0;
  logic [NCH-1:0]  clk_out;

  int  n_run = 0;
  int  n_fail = 0;
  bit  mon_on = 1'b0;
  int  runt [NCH];
  int  rises [NCH];
  real t_rise [NCH];
  real t_fall [NCH];
  logic [NCH-1:0] prev_out = '0;
  logic [NSEL-1:0] map_cur = '0;

  always #4 bclk = ~bclk;
  initial begin #0.3; forever #10 clk_a = ~clk_a; end
  initial begin #0.7; forever #7  clk_b = ~clk_b; end

  clk_freq_select #(.NCH(NCH), .NSEL(NSEL), .NPIN(NPIN)) uut (
    .rst_n(rst_n), .fs_pin(fs_pin), .map_sel(map_sel),
    .clk_a(clk_a), .clk_b(clk_b), .clk_out(clk_out)
  );

  initial begin
    for (int c = 0; c < NCH; c++) begin
      runt[c] = 0; rises[c] = 0; t_rise[c] = -1.0; t_fall[c] = -1.0;
    end
  end

  // Pulse-width monitor for R6 and R7.
  always @(clk_out) begin
    for (int c = 0; c < NCH; c++) begin
      if (clk_out[c] !== prev_out[c]) begin
        if (!mon_on) begin
          t_rise[c] = -1.0; t_fall[c] = -1.0;
        end else if (clk_out[c] === 1'b1) begin
          if (t_fall[c] >= 0.0 && ($realtime - t_fall[c]) < 6.99) runt[c]++;
          t_rise[c] = $realtime;
          rises[c]++;
        end else begin
          if (t_rise[c] >= 0.0) begin
            real w;
            w = $realtime - t_rise[c];
            if (!((w > 9.99 && w < 10.01) || (w > 6.99 && w < 7.01))) runt[c]++;
          end
          t_fall[c] = $realtime;
        end
      end
    end
    prev_out = clk_out;
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // Compare every channel against its expected source over nsamp samples.
  task automatic chk_all(input logic [NSEL-1:0] want_b, input int nsamp, input string tag);
    int bad [NCH];
    for (int c = 0; c < NCH; c++) bad[c] = 0;
    for (int k = 0; k < nsamp; k++) begin
      @(negedge bclk);
      for (int c = 0; c < NCH; c++) begin
        logic e;
        e = (c < NSEL && want_b[c]) ? clk_b[c] : clk_a[c];
        if (clk_out[c] !== e) bad[c]++;
      end
    end
    for (int c = 0; c < NCH; c++) begin
      n_run++;
      if (bad[c] != 0) begin
        n_fail++;
        $display("FAIL %s ch%0d: %0d mismatched samples (expected 0), expected source %s",
                 (c >= NSEL) ? "R5" : tag, c, bad[c],
                 (c < NSEL && want_b[c]) ? "B" : "A");
      end
    end
  endtask

  task automatic do_reset(input logic [NSEL-1:0] m);
    mon_on = 1'b0;
    @(posedge bclk);
    rst_n = 1'b0;
    map_sel = m;
    repeat (8) @(posedge bclk);
    rst_n = 1'b1;
    map_cur = m;
    repeat (2) @(posedge bclk);
    mon_on = 1'b1;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    summary();
    $finish;
  end

  initial begin
    // R1: reset holds A regardless of pins.
    map_sel = 6'b111111;
    fs_pin  = 2'b11;
    repeat (20) @(posedge bclk);
    chk_all('0, 8, "R1 in reset");
    rst_n = 1'b1;
    map_cur = 6'b111111;
    chk_all('0, 3, "R1 just after release");
    mon_on = 1'b1;
    repeat (SETTLE) @(posedge bclk);
    chk_all('1, 16, "R2 switch to B");

    // R2/R3: table walk.
    for (int r = 0; r < 9; r++) begin
      if (ROWS[r].map != map_cur) do_reset(ROWS[r].map);
      fs_pin = ROWS[r].fs;
      repeat (SETTLE) @(posedge bclk);
      chk_all(ROWS[r].want_b, 16, "R2 R3 mapped select");
    end

    // R4: map changes out of reset are ignored (latched map 010110).
    map_sel = 6'b101001;
    fs_pin  = 2'b01;
    repeat (SETTLE) @(posedge bclk);
    chk_all(6'b101001, 16, "R4 map ignored");
    fs_pin  = 2'b10;
    repeat (SETTLE) @(posedge bclk);
    chk_all(6'b010110, 16, "R4 map ignored");

    // R5: pins toggling while fixed channels are watched.
    fs_pin = 2'b11;
    repeat (SETTLE) @(posedge bclk);
    chk_all('1, 16, "R5 R2 both pins high");

    // R6/R7: no runt pulses, and the output kept running.
    for (int c = 0; c < NCH; c++) begin
      n_run++;
      if (runt[c] != 0 || rises[c] == 0) begin
        n_fail++;
        $display("FAIL R6 R7 ch%0d: %0d bad pulses, %0d rises (expected 0 bad, >0 rises)",
                 c, runt[c], rises[c]);
      end
    end

    summary();
    $finish;
  end
endmodule